// File: doc/BRIEF.md
# Saturating Parity Error Counter

This block tallies parity errors flagged by a receive datapath, one pulse per received word in error. While the link is locked and checking is enabled, each flagged word adds one to a 16-bit error count. The count never passes a 16-bit limit that software writes one byte at a time. A sticky status flag goes high once any error has been counted. A held, level-sensitive clear input keeps the count, the flag and the test-mode count at zero for as long as it is high.

While the self-test mode input is high, flagged words go to a separate 8-bit counter that stops at its maximum, and the normal count is left alone. The count is read as two bytes. The low byte is always live. A read strobe on the low byte copies the high byte into a holding register, so a low-then-high read returns one consistent value even while errors keep arriving.

Top module: `parity_err_tally`

## Requirements
- R1: Coming out of reset, the count is 0, the high-byte holding register is 0, the status flag is 0, the test-mode count is 0 and the limit reads 0x0100.
- R2: An accepted error is a cycle with `perr_i`, `lock_i` and `chk_en_i` high, and `bist_i` and `cnt_clr_i` low. Each accepted error raises the count by exactly one, visible after the next rising clock edge.
- R3: The count never exceeds the limit. Accepted errors at the limit leave the count unchanged. A limit write that lowers the limit below the count clamps the count to the new limit on the same clock edge.
- R4: The status flag rises on the first accepted error and stays high until `cnt_clr_i` is asserted.
- R5: While `cnt_clr_i` is high, the count, the status flag and the test-mode count are all 0 after each clock edge. The input does not clear itself, and counting resumes on the first edge after it falls.
- R6: With `chk_en_i` low, flagged words change neither the count nor the test-mode count.
- R7: With `bist_i` high, a flagged word (locked, enabled, not clearing) raises the test-mode count by one and changes neither the normal count nor the status flag.
- R8: With `lock_i` low, flagged words change no count and no flag.
- R9: The test-mode count stops at 255.
- R10: The `thr_we_lo_i` strobe writes `thr_wdata_i` into limit bits 7:0, and the `thr_we_hi_i` strobe writes it into limit bits 15:8. The new value shows on `thr_o` after the clock edge.
- R11: A cycle with `rd_lo_i` high captures count bits 15:8 as they stand in that cycle into `cnt_hi_o`. `cnt_hi_o` then holds that value until the next `rd_lo_i`, whatever the count does. `cnt_lo_o` always shows count bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| perr_i | input | 1 | Parity error flagged on the current word |
| lock_i | input | 1 | Receive link locked |
| chk_en_i | input | 1 | Parity checking enabled |
| cnt_clr_i | input | 1 | Level-sensitive clear of the counts and the flag |
| bist_i | input | 1 | Self-test mode; errors go to the test-mode count |
| thr_we_lo_i | input | 1 | Write strobe for limit bits 7:0 |
| thr_we_hi_i | input | 1 | Write strobe for limit bits 15:8 |
| thr_wdata_i | input | 8 | Limit byte write data |
| rd_lo_i | input | 1 | Low-byte read strobe; captures the high byte |
| thr_o | output | 16 | Current limit |
| cnt_lo_o | output | 8 | Count bits 7:0, live |
| cnt_hi_o | output | 8 | Count bits 15:8, as captured by the last low-byte read |
| perr_flag_o | output | 1 | Sticky status: an error has been counted |
| bist_cnt_o | output | 8 | Test-mode error count |

## Verification
The assertions assume that every input is synchronous to the clock and stable around the rising edge. The bench keeps to this by driving all inputs on the falling edge. The stability properties for the normal count apply only in cycles with no limit write, because a limit write may legally clamp the count. The step property excludes the same cycles. The bench keeps limit writes apart from the windows where it checks gating, so that no clamp and no count change fall in the same cycle.

// File: rtl/perr_pkg.sv
package perr_pkg;
  // Where an incoming error goes in a given cycle.
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_NORM = 2'd1,
    ROUTE_BIST = 2'd2
  } err_route_e;
endpackage

// File: rtl/perr_rst_sync.sv
module perr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/perr_thr_reg.sv
module perr_thr_reg #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NBYTES  = 2,
  parameter int unsigned RST_VAL = 256
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NBYTES-1:0]          we_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [NBYTES*BYTE_W-1:0]   thr_nxt_o,
  output logic [NBYTES*BYTE_W-1:0]   thr_q_o
);
  localparam int unsigned W = NBYTES * BYTE_W;
  localparam logic [W-1:0] RST_V = W'(RST_VAL);

  logic [W-1:0] thr_q;
  logic [W-1:0] thr_d;
  logic         thr_en;

  // One write lane per byte of the limit.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign thr_d[g*BYTE_W +: BYTE_W] = we_i[g] ? wdata_i : thr_q[g*BYTE_W +: BYTE_W];
  end

  assign thr_en = |we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     thr_q <= RST_V;
    else if (thr_en) thr_q <= thr_d;
  end

  assign thr_nxt_o = thr_d;
  assign thr_q_o   = thr_q;
endmodule

// File: rtl/perr_sat_ctr.sv
module perr_sat_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // The limit is the value that applies after this edge, so a lowered
  // limit clamps the count in the same cycle it is written.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (cnt_q > limit_i) begin
      cnt_d  = limit_i;
      cnt_en = 1'b1;
    end else if (inc_i && (cnt_q < limit_i)) begin
      cnt_d  = cnt_q + W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perr_rd_latch.sv
module perr_rd_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= d_i;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/parity_err_tally.sv
module parity_err_tally
  import perr_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned BIST_W  = 8,
  parameter int unsigned THR_RST = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                perr_i,
  input  logic                lock_i,
  input  logic                chk_en_i,
  input  logic                cnt_clr_i,
  input  logic                bist_i,
  input  logic                thr_we_lo_i,
  input  logic                thr_we_hi_i,
  input  logic [BYTE_W-1:0]   thr_wdata_i,
  input  logic                rd_lo_i,
  output logic [2*BYTE_W-1:0] thr_o,
  output logic [BYTE_W-1:0]   cnt_lo_o,
  output logic [BYTE_W-1:0]   cnt_hi_o,
  output logic                perr_flag_o,
  output logic [BIST_W-1:0]   bist_cnt_o
);
  localparam int unsigned NBYTES = 2;
  localparam int unsigned CNT_W  = NBYTES * BYTE_W;

  logic              rst_sync_n;
  logic [CNT_W-1:0]  thr_q;
  logic [CNT_W-1:0]  thr_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIST_W-1:0] bist_q;
  err_route_e        route;
  logic              flag_q;
  logic              flag_d;

  perr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // Decide where this cycle's error, if any, is counted.
  always_comb begin
    route = ROUTE_NONE;
    if (perr_i && lock_i && chk_en_i && !cnt_clr_i) begin
      route = bist_i ? ROUTE_BIST : ROUTE_NORM;
    end
  end

  perr_thr_reg #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .RST_VAL(THR_RST)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .we_i      ({thr_we_hi_i, thr_we_lo_i}),
    .wdata_i   (thr_wdata_i),
    .thr_nxt_o (thr_nxt),
    .thr_q_o   (thr_q)
  );

  perr_sat_ctr #(.W(CNT_W)) u_norm (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .clr_i   (cnt_clr_i),
    .inc_i   (route == ROUTE_NORM),
    .limit_i (thr_nxt),
    .cnt_o   (cnt_q)
  );

  perr_sat_ctr #(.W(BIST_W)) u_bist (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .clr_i   (cnt_clr_i),
    .inc_i   (route == ROUTE_BIST),
    .limit_i ({BIST_W{1'b1}}),
    .cnt_o   (bist_q)
  );

  // Sticky status: set by any normal-mode accepted error, dropped by clear.
  always_comb begin
    flag_d = flag_q | (route == ROUTE_NORM);
    if (cnt_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  perr_rd_latch #(.W(BYTE_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cap_i  (rd_lo_i),
    .d_i    (cnt_q[CNT_W-1:BYTE_W]),
    .q_o    (cnt_hi_o)
  );

  assign thr_o       = thr_q;
  assign cnt_lo_o    = cnt_q[BYTE_W-1:0];
  assign perr_flag_o = flag_q;
  assign bist_cnt_o  = bist_q;
endmodule

// File: rtl/perr_tally_chk.sv
module perr_tally_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              perr_i,
  input logic              lock_i,
  input logic              chk_en_i,
  input logic              cnt_clr_i,
  input logic              bist_i,
  input logic              thr_wr_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  thr_i,
  input logic              flag_i,
  input logic [BIST_W-1:0] bist_cnt_i
);
  assert_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= thr_i);

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !thr_wr_i) |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1));

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !cnt_clr_i) |=> flag_i);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_i == '0) && !flag_i && (bist_cnt_i == '0));

  assert_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_en_i && !cnt_clr_i && !thr_wr_i) |=> $stable(cnt_i) && $stable(bist_cnt_i));

  assert_bist_sep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_i && !cnt_clr_i && !thr_wr_i) |=> $stable(cnt_i) && $stable(flag_i));

  assert_unlocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !cnt_clr_i && !thr_wr_i) |=> $stable(cnt_i) && $stable(flag_i) && $stable(bist_cnt_i));

  assert_bist_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&bist_cnt_i) && !cnt_clr_i) |=> (&bist_cnt_i));

  // Input sanity on the error pulse is not needed; perr_i listed for completeness.
  logic unused_perr;
  assign unused_perr = perr_i;
endmodule

bind parity_err_tally perr_tally_chk #(.CNT_W(CNT_W), .BIST_W(BIST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .perr_i     (perr_i),
  .lock_i     (lock_i),
  .chk_en_i   (chk_en_i),
  .cnt_clr_i  (cnt_clr_i),
  .bist_i     (bist_i),
  .thr_wr_i   (thr_we_lo_i | thr_we_hi_i),
  .cnt_i      (cnt_q),
  .thr_i      (thr_q),
  .flag_i     (flag_q),
  .bist_cnt_i (bist_q)
);

// File: tb/sim_parity_err_tally.sv
`timescale 1ns/1ps
module sim_parity_err_tally;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       perr, lock, en, clr, bist, we_lo, we_hi, rd_lo;
  logic [7:0] wdata;
  logic [15:0] thr;
  logic [7:0] lo, hi, bcnt;
  logic       flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  parity_err_tally u0 (
    .clk_i(clk), .rst_ni(rst_n), .perr_i(perr), .lock_i(lock), .chk_en_i(en),
    .cnt_clr_i(clr), .bist_i(bist), .thr_we_lo_i(we_lo), .thr_we_hi_i(we_hi),
    .thr_wdata_i(wdata), .rd_lo_i(rd_lo), .thr_o(thr), .cnt_lo_o(lo),
    .cnt_hi_o(hi), .perr_flag_o(flag), .bist_cnt_o(bcnt)
  );

  // Vector: {perr,lock,en,bist,clr}, expected {cnt_lo, flag, bist_cnt} after one edge.
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {5'b11100, 8'd1, 1'b1, 8'd0},  // R2 R4 first error
    {5'b11100, 8'd2, 1'b1, 8'd0},  // R2 second error
    {5'b10100, 8'd2, 1'b1, 8'd0},  // R8 unlocked
    {5'b11000, 8'd2, 1'b1, 8'd0},  // R6 disabled
    {5'b01100, 8'd2, 1'b1, 8'd0},  // no error
    {5'b11110, 8'd2, 1'b1, 8'd1},  // R7 test mode
    {5'b11110, 8'd2, 1'b1, 8'd2},  // R7 test mode
    {5'b11010, 8'd2, 1'b1, 8'd2},  // R6 disabled in test mode
    {5'b11101, 8'd0, 1'b0, 8'd0},  // R5 clear
    {5'b11101, 8'd0, 1'b0, 8'd0},  // R5 clear held
    {5'b11100, 8'd1, 1'b1, 8'd0},  // R5 resumes
    {5'b00000, 8'd1, 1'b1, 8'd0}   // R4 sticky
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic errors(input int n);
    perr = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    perr = 1'b0;
  endtask

  task automatic read_lo();
    rd_lo = 1'b1; cyc(); rd_lo = 1'b0;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; perr = 0; lock = 1; en = 1; clr = 0; bist = 0;
    we_lo = 0; we_hi = 0; wdata = '0; rd_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    check("R1 thr", thr, 32'h0100);
    check("R1 cnt", {hi, lo}, 32'h0);
    check("R1 flag/bist", {flag, bcnt}, 32'h0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      {perr, lock, en, bist, clr} = VEC[v][21:17];
      cyc();
      check($sformatf("R2 R4 R5 R6 R7 R8 vector %0d", v), {lo, flag, bcnt}, {8'h0, VEC[v][16:0]});
    end
    perr = 0; lock = 1; en = 1; bist = 0; clr = 0;

    // R3 saturation at default limit 256
    clr = 1; cyc(); clr = 0;
    errors(300);
    read_lo();
    check("R3 saturate at 0x0100", {hi, lo}, 32'h0100);
    // R11 hold: clear count, latched high byte must stay
    clr = 1; cyc(); clr = 0;
    check("R11 lo live after clear", lo, 32'h0);
    check("R11 hi held", hi, 32'h01);
    read_lo();
    check("R11 hi recaptured", hi, 32'h00);

    // R10 limit writes, R3 clamp on lowering
    errors(20);
    check("R2 count 20", lo, 32'd20);
    wdata = 8'h05; we_lo = 1; cyc(); we_lo = 0;
    check("R10 low byte write", thr, 32'h0105);
    check("R3 no clamp above", lo, 32'd20);
    wdata = 8'h00; we_hi = 1; cyc(); we_hi = 0;
    check("R10 high byte write", thr, 32'h0005);
    check("R3 clamp same edge", lo, 32'd5);
    errors(3);
    check("R3 hold at limit 5", lo, 32'd5);

    // R9 test-mode saturation
    bist = 1; errors(260); bist = 0;
    check("R9 bist saturates", bcnt, 32'd255);
    check("R7 normal untouched", lo, 32'd5);
    clr = 1; cyc(); clr = 0;
    check("R5 bist cleared", {flag, bcnt}, 32'h0);

    finish_up();
  end
endmodule